// File: doc/BRIEF.md
# SPI Slave Memory-Access Bridge

This block lets an external SPI host read and write a 16-bit addressed data memory inside the chip. Each transaction runs while chip select is held low. It opens with an 8-bit command byte and a 16-bit address. After that, any number of data bytes follow. Data bytes are either written into memory or shifted back out of it, and the address steps forward by one after every byte. A single transaction can therefore move a burst of any length.

The serial inputs are brought into the system clock domain through synchronizer flops, and all decoding runs on the system clock. The memory side is a plain synchronous port:

- a one-cycle write strobe with address and data;
- a one-cycle read strobe, whose data returns on the next cycle.

A host write can also raise a one-cycle notification pulse toward the local processor. The command byte decides whether this pulse is raised.

The serial clock runs in SPI mode 0. The host must hold each level of the serial clock for at least four system clock cycles.

Top module: `spibr_top`

## Requirements
- R1: While reset is held and after it is released, `spi_miso_en`, `mem_we`, `mem_re` and `wr_irq` are all 0 until a transaction supplies data.
- R2: The first 8 bits after chip select falls form the command, and the next 16 bits form the address, both sent MSB first. Command bit 7 set to 1 selects a read and 0 selects a write. Command bits 5 to 0 have no effect.
- R3: In a write, each completed 8-bit data byte (MSB first) issues one `mem_we` pulse of one cycle. The pulse carries that byte on `mem_wdata`, and its address is the transaction address for the first byte.
- R4: Each further data byte of a transaction uses the previous address plus one, for both reads and writes. The address wraps from 0xFFFF to 0x0000.
- R5: In a read, `mem_re` pulses once when the last address bit arrives and once at each later byte boundary. `mem_rdata` is taken one cycle after the pulse. Its bits appear on `spi_miso` MSB first, each changing after a falling serial clock edge, so the host can sample it on the rising edge.
- R6: `spi_miso_en` is 0 outside a transaction, during the command and address bits, and throughout a write. It is 1 while read data is being shifted out.
- R7: When command bit 6 is 1 in a write, `wr_irq` pulses for one cycle in the same cycle as each `mem_we`. It never pulses when bit 6 is 0, and never during a read.
- R8: If chip select rises part-way through a byte, that partial byte produces no write. The next transaction starts again with a fresh command byte.
- R9: `mem_we` and `mem_re` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data toward the host |
| spi_miso_en | output | 1 | Output enable for the external data-out pad buffer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_re | output | 1 | Memory read strobe, one cycle |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |
| wr_irq | output | 1 | Write notification pulse to the processor |

## Verification
Two of this block's functions can fall in the same cycle.

The first overlap is in a write. The last bit of a data byte arriving commits the memory write. If the notification bit is set, the notification pulse goes out in that same cycle, and the burst address advances at the same moment. The reference model queues one expected write per completed byte, holding address, data and notification flag. On every clock it compares the strobe, address, data and pulse against the front of that queue.

The second overlap is in a read. The byte-boundary memory read has to land while the last bit of the previous byte is still on the output line. This is provoked with read bursts, including one that crosses the 0xFFFF wrap. The bench judges it by comparing each bit the host samples on a rising clock edge with its own shadow copy of memory.

Aborting a write one bit short of a byte boundary checks that chip select release takes priority over byte completion.

// File: rtl/spibr_pkg.sv
package spibr_pkg;

   // Transaction phase after chip select falls
   typedef enum logic [1:0] {
      PH_HDR = 2'd0,
      PH_WR  = 2'd1,
      PH_RD  = 2'd2
   } phase_e;

endpackage

// File: rtl/spibr_sync.sv
module spibr_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spibr_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/spibr_rx.sv
module spibr_rx
   import spibr_pkg::*;
#(
   parameter int CMD_W   = 8,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int RD_BIT  = 7,
   parameter int IRQ_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              rise_i,
   input  logic              mosi_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_we_o,
   output logic              mem_re_o,
   output logic              irq_o,
   output logic              rd_phase_o
);

   localparam int HDR_W  = CMD_W + ADDR_W;
   localparam int CNT_W  = $clog2(HDR_W + 1);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int TOPBIT = (RD_BIT > IRQ_BIT) ? RD_BIT : IRQ_BIT;
   localparam int SR_W   = ADDR_W + TOPBIT;

   phase_e            phase;
   logic [CNT_W-1:0]  hdr_cnt;
   logic [SR_W-1:0]   hdr_sr;
   logic [BIT_W-1:0]  bit_idx;
   logic [DATA_W-2:0] din_sr;
   logic [ADDR_W-1:0] next_addr;
   logic              irq_en;
   logic [ADDR_W-1:0] hdr_addr;
   logic              hdr_rd;
   logic              hdr_irq;

   // Header fields as seen with the current bit appended
   assign hdr_addr = {hdr_sr[ADDR_W-2:0], mosi_i};
   assign hdr_rd   = hdr_sr[ADDR_W + RD_BIT - 1];
   assign hdr_irq  = hdr_sr[ADDR_W + IRQ_BIT - 1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_HDR;
         hdr_cnt     <= '0;
         hdr_sr      <= '0;
         bit_idx     <= '0;
         din_sr      <= '0;
         next_addr   <= '0;
         irq_en      <= 1'b0;
         mem_addr_o  <= '0;
         mem_wdata_o <= '0;
         mem_we_o    <= 1'b0;
         mem_re_o    <= 1'b0;
         irq_o       <= 1'b0;
      end else begin
         mem_we_o <= 1'b0;
         mem_re_o <= 1'b0;
         irq_o    <= 1'b0;
         if (!active_i) begin
            phase   <= PH_HDR;
            hdr_cnt <= '0;
            bit_idx <= '0;
         end else if (rise_i) begin
            if (phase == PH_HDR) begin
               hdr_sr <= {hdr_sr[SR_W-2:0], mosi_i};
               if (hdr_cnt == CNT_W'(HDR_W - 1)) begin
                  hdr_cnt <= '0;
                  bit_idx <= '0;
                  irq_en  <= hdr_irq;
                  if (hdr_rd) begin
                     phase      <= PH_RD;
                     mem_re_o   <= 1'b1;
                     mem_addr_o <= hdr_addr;
                     next_addr  <= hdr_addr + 1'b1;
                  end else begin
                     phase     <= PH_WR;
                     next_addr <= hdr_addr;
                  end
               end else begin
                  hdr_cnt <= hdr_cnt + 1'b1;
               end
            end else begin
               din_sr <= {din_sr[DATA_W-3:0], mosi_i};
               if (bit_idx == BIT_W'(DATA_W - 1)) begin
                  bit_idx    <= '0;
                  mem_addr_o <= next_addr;
                  next_addr  <= next_addr + 1'b1;
                  if (phase == PH_WR) begin
                     mem_we_o    <= 1'b1;
                     mem_wdata_o <= {din_sr, mosi_i};
                     irq_o       <= irq_en;
                  end else begin
                     mem_re_o <= 1'b1;
                  end
               end else begin
                  bit_idx <= bit_idx + 1'b1;
               end
            end
         end
      end
   end

   assign rd_phase_o = (phase == PH_RD);

endmodule

// File: rtl/spibr_tx.sv
module spibr_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              rd_phase_i,
   input  logic              fall_i,
   input  logic              re_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              miso_o,
   output logic              miso_en_o
);

   logic              load_q;
   logic [DATA_W-1:0] tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q    <= 1'b0;
         tx_sr     <= '0;
         miso_o    <= 1'b0;
         miso_en_o <= 1'b0;
      end else begin
         load_q <= re_i;
         if (!active_i) begin
            miso_o    <= 1'b0;
            miso_en_o <= 1'b0;
         end else if (load_q) begin
            tx_sr <= rdata_i;
         end else if (fall_i && rd_phase_i) begin
            miso_o    <= tx_sr[DATA_W-1];
            tx_sr     <= {tx_sr[DATA_W-2:0], 1'b0};
            miso_en_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/spibr_top.sv
module spibr_top #(
   parameter int CMD_W       = 8,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int RD_BIT      = 7,
   parameter int IRQ_BIT     = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wr_irq
);

   if (RD_BIT >= CMD_W || IRQ_BIT >= CMD_W || RD_BIT == IRQ_BIT) begin : g_bad_cmd
      $error("spibr_top: command bit positions invalid");
   end
   if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("spibr_top: DATA_W must be a power of two, at least 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("spibr_top: ADDR_W too small");
   end

   logic [2:0] pins_s;
   logic       cs_n_s, sclk_s, mosi_s;
   logic       sclk_prev;
   logic       rise, fall, active;
   logic       rd_phase;

   spibr_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_mosi, spi_sclk, spi_cs_n}),
      .q_o   (pins_s)
   );

   assign cs_n_s = pins_s[0];
   assign sclk_s = pins_s[1];
   assign mosi_s = pins_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign rise   = sclk_s & ~sclk_prev;
   assign fall   = ~sclk_s & sclk_prev;
   assign active = ~cs_n_s;

   spibr_rx #(
      .CMD_W   (CMD_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RD_BIT  (RD_BIT),
      .IRQ_BIT (IRQ_BIT)
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (active),
      .rise_i      (rise),
      .mosi_i      (mosi_s),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .mem_we_o    (mem_we),
      .mem_re_o    (mem_re),
      .irq_o       (wr_irq),
      .rd_phase_o  (rd_phase)
   );

   spibr_tx #(
      .DATA_W (DATA_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (active),
      .rd_phase_i (rd_phase),
      .fall_i     (fall),
      .re_i       (mem_re),
      .rdata_i    (mem_rdata),
      .miso_o     (spi_miso),
      .miso_en_o  (spi_miso_en)
   );

endmodule

// File: rtl/spibr_checker.sv
module spibr_checker (
   input logic clk,
   input logic rst_n,
   input logic spi_cs_n,
   input logic spi_miso_en,
   input logic mem_we,
   input logic mem_re,
   input logic wr_irq
);

   // Cycles since reset, saturating, guards $past look-back
   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 3'd7) age <= age + 1'b1;
   end

   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_irq_needs_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_irq |-> mem_we);

   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_irq |=> !wr_irq);

   p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   p_re_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re);

   // R6 / R1: long after chip select is released everything is quiet
   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd6 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)
       && $past(spi_cs_n, 3) && $past(spi_cs_n, 4) && $past(spi_cs_n, 5))
      |-> (!spi_miso_en && !mem_we && !mem_re && !wr_irq));

endmodule

bind spibr_top spibr_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spi_cs_n    (spi_cs_n),
   .spi_miso_en (spi_miso_en),
   .mem_we      (mem_we),
   .mem_re      (mem_re),
   .wr_irq      (wr_irq)
);

// File: tb/spibr_top_tb_top.sv
module spibr_top_tb_top;

   localparam int HALF = 4;

   typedef struct packed {
      logic        irq;
      logic [15:0] a;
      logic [7:0]  d;
   } wr_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_sclk = 1'b0;
   logic        spi_mosi = 1'b0;
   logic        spi_miso, spi_miso_en;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we, mem_re, wr_irq;
   logic [7:0]  mem_rdata = 8'h00;

   int  nvec = 0;
   int  nfail = 0;
   bit  done = 0;

   logic [7:0] mem_m  [int];
   logic [7:0] shadow [int];
   wr_t        wq[$];
   logic [7:0] byte_q[$];

   always #5 clk = ~clk;

   spibr_top dut_i (
      .clk (clk), .rst_n (rst_n),
      .spi_cs_n (spi_cs_n), .spi_sclk (spi_sclk), .spi_mosi (spi_mosi),
      .spi_miso (spi_miso), .spi_miso_en (spi_miso_en),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_we (mem_we), .mem_re (mem_re),
      .mem_rdata (mem_rdata), .wr_irq (wr_irq)
   );

   // Memory model: data returns the cycle after the read strobe
   always @(posedge clk) begin
      if (mem_we) mem_m[int'(mem_addr)] = mem_wdata;
      if (mem_re) mem_rdata <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Per-clock comparison of the memory side against the expected write queue
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mem_we && mem_re) chk(0, "R9", "we and re together", 1, 0);
         if (wr_irq && !mem_we) chk(0, "R7", "irq without write", 1, 0);
         if (mem_we) begin
            if (wq.size() == 0) begin
               chk(0, "R3", "unexpected write addr", {16'h0, mem_addr}, 0);
            end else begin
               wr_t e;
               e = wq.pop_front();
               chk(mem_addr == e.a, "R4", "write address", {16'h0, mem_addr}, {16'h0, e.a});
               chk(mem_wdata == e.d, "R3", "write data", {24'h0, mem_wdata}, {24'h0, e.d});
               chk(wr_irq == e.irq, "R7", "irq pulse", {31'h0, wr_irq}, {31'h0, e.irq});
            end
         end
      end
   end

   function automatic logic [7:0] shadow_rd(input logic [15:0] a);
      return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
   endfunction

   // One serial bit: low phase, sample, high phase
   task automatic sbit(input logic b, input bit rd_chk, input logic exp_d,
                       input bit in_hdr, input string tag);
      spi_mosi = b;
      repeat (HALF) @(negedge clk);
      if (in_hdr)
         chk(spi_miso_en == 1'b0, "R6", {tag, " oe in header"}, {31'h0, spi_miso_en}, 0);
      if (rd_chk) begin
         chk(spi_miso_en == 1'b1, "R6", {tag, " oe in read"}, {31'h0, spi_miso_en}, 1);
         chk(spi_miso == exp_d, "R5", {tag, " read bit"}, {31'h0, spi_miso}, {31'h0, exp_d});
      end
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
   endtask

   // R2: header is command then address, MSB first; bit7 read, bit6 irq
   task automatic xfer(input logic [7:0] cmd, input logic [15:0] addr,
                       input int nb, input int extra_bits, input string tag);
      logic [23:0] hdr;
      hdr = {cmd, addr};
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 23; i >= 0; i--) sbit(hdr[i], 0, 1'b0, 1, tag);
      for (int k = 0; k < nb; k++) begin
         logic [15:0] a;
         logic [7:0]  v;
         a = addr + 16'(k);
         if (cmd[7]) begin
            v = shadow_rd(a);
         end else begin
            v = byte_q[k];
            shadow[int'(a)] = v;
            wq.push_back('{irq: cmd[6], a: a, d: v});
         end
         for (int i = 7; i >= 0; i--) sbit(cmd[7] ? 1'b0 : v[i], cmd[7], v[i], 0, tag);
      end
      for (int i = 0; i < extra_bits; i++) sbit(1'b1, 0, 1'b0, 0, tag);
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(wq.size() == 0, "R3", {tag, " writes outstanding"}, wq.size(), 0);
      chk(spi_miso_en == 1'b0, "R6", {tag, " oe after cs"}, {31'h0, spi_miso_en}, 0);
      wq.delete();
   endtask

   initial begin
      mem_m[16'hFFFF] = 8'h5C; shadow[16'hFFFF] = 8'h5C;
      mem_m[0]        = 8'hC3; shadow[0]        = 8'hC3;
      repeat (3) @(negedge clk);
      // R1: state during and after reset
      chk(!spi_miso_en && !mem_we && !mem_re && !wr_irq, "R1", "reset outputs",
          {28'h0, spi_miso_en, mem_we, mem_re, wr_irq}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!spi_miso_en && !mem_we && !mem_re && !wr_irq, "R1", "after reset",
          {28'h0, spi_miso_en, mem_we, mem_re, wr_irq}, 0);

      // R3 R7: single write with notification
      byte_q = '{8'hA5};
      xfer(8'h40, 16'h1234, 1, 0, "R3 single write irq");

      // R4: burst write across a 256 boundary, no notification
      byte_q = '{8'h11, 8'h22, 8'h33};
      xfer(8'h00, 16'h12FE, 3, 0, "R4 burst write");

      // R2: low command bits set have no effect
      byte_q = '{8'h7E};
      xfer(8'h3F, 16'h0100, 1, 0, "R2 ignored bits");

      // R5 R4: burst read back
      xfer(8'h80, 16'h12FE, 4, 0, "R5 burst read");

      // R4: read wrap 0xFFFF -> 0x0000
      xfer(8'h80, 16'hFFFF, 2, 0, "R4 read wrap");

      // R7: read with notification bit set raises nothing
      xfer(8'hC0, 16'h1234, 1, 0, "R7 read no irq");

      // R8: abort after one full byte plus seven bits
      byte_q = '{8'h5A};
      xfer(8'h40, 16'h2000, 1, 7, "R8 abort");

      // R8: next transaction starts with a fresh header; 0x2001 untouched
      xfer(8'h80, 16'h2000, 2, 0, "R8 restart read");

      // R3: write of all ones then all zeros
      byte_q = '{8'hFF, 8'h00};
      xfer(8'h40, 16'hABCD, 2, 0, "R3 extremes");
      xfer(8'h80, 16'hABCD, 2, 0, "R5 extremes read");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         nvec++;
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule